// File: doc/BRIEF.md
# Typed-Access Control/Status Register Bank

This block is a small register bank behind a 32-bit AXI4-Lite slave port. Each of its seven word registers follows one typed access rule. The rules are plain storage, live hardware status, write-triggered pulses, clear-by-writing-one flags, set-by-writing-one enables, clear-on-read event bits, and self-clearing start bits. For every bit, the bank keeps what a read returns separate from what a write does. Each bit also merges the software effect with a hardware-side set, clear or value input in the same clock.

Software programs the bank through the bus. Neighbouring logic uses the per-field hardware ports:
- It drives status, event, clear-request and completion inputs.
- It consumes the configuration, enable, busy and trigger outputs.

The bus channels follow standard valid/ready rules:
- **Writes:** a write is taken only when address and data are both presented and no write response is waiting. A response is held, unchanged, until the master raises its ready.
- **Reads:** a read is taken only while no read response is waiting. Its response is held the same way.
- **Capacity:** the bank holds at most one write and one read at a time.

Top module: `csr_typed_bank`

## Requirements
- R1: The register at byte offset 0x00 is plain storage. A read returns the last value written, and `cfg_o` shows it from the cycle after the write handshake. Reset value is 0.
- R2: Offset 0x04 returns the value of `hw_status_i` sampled at the read handshake. A write there changes nothing. With `RO_WR_SLVERR`=1 (the default) the write answers SLVERR (2'b10); with 0 it answers OKAY.
- R3: A write to offset 0x08 drives `trig_o` with the written, lane-enabled data for exactly the one cycle after the handshake; otherwise `trig_o` is 0. A read of 0x08 returns 0.
- R4: At offset 0x0C each bit written as 1 clears, and each bit written as 0 is kept. `evt_set_i` sets bits. A set arriving in the same cycle as a clear on that bit leaves the bit at 1.
- R5: At offset 0x10 each bit written as 1 sets, and each bit written as 0 is kept. The bits drive `arm_o`. `arm_clr_i` clears bits, and a software set in the same cycle wins over it.
- R6: Offset 0x14 returns its bits and clears them on the read address handshake. `rc_evt_i` sets bits, and an event in the handshake cycle survives into the next value. Writes there change nothing.
- R7: At offset 0x18 writing 1 sets a start bit, shown on `go_o` and read back as 1 while busy. `done_i` clears it. A software set in the same cycle as a done wins.
- R8: Byte lanes whose `s_wstrb` bit is low leave their 8 bits untouched for every register.
- R9: Accepted accesses answer OKAY (2'b00). Addresses outside 0x00..0x18 and unaligned addresses answer DECERR (2'b11) with read data 0 and no state change.
- R10: A write is taken only with both valids high and no pending write response. A read is taken only with no pending read response. Each response stays valid and stable until its ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| hw_status_i | input | 32 | Live status value for offset 0x04 |
| evt_set_i | input | 32 | Per-bit set pulses for the flag register |
| arm_clr_i | input | 32 | Per-bit clear pulses for the enable register |
| rc_evt_i | input | 32 | Per-bit event pulses for the clear-on-read register |
| done_i | input | 32 | Per-bit completion pulses for the start register |
| cfg_o | output | 32 | Storage register contents |
| trig_o | output | 32 | One-cycle trigger pulses |
| arm_o | output | 32 | Enable register contents |
| go_o | output | 32 | Start/busy bits |

## Verification
The bank is exercised with three kinds of write:
- Full-word writes show whether each access type applies its rule at all.
- Partial-strobe writes separate a correct lane mask from one that ignores or misroutes strobes.
- All-zero data writes show that a 0 truly keeps a bit rather than storing it.

Hardware pulses are timed onto the very cycle of a bus handshake. These collisions expose a wrong priority between software and hardware, and a clear-on-read that swallows a same-cycle event.

Response back-pressure and probes of unmapped, unaligned and status addresses distinguish a correct response hold and error code from a bank that drops, alters or misclassifies responses.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_STAT = 3'd1,
    SEL_TRIG = 3'd2,
    SEL_FLAG = 3'd3,
    SEL_ARM  = 3'd4,
    SEL_RC   = 3'd5,
    SEL_GO   = 3'd6,
    SEL_NONE = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef struct packed {
    logic [WORD_W-1:0] cfg;
    logic [WORD_W-1:0] flag;
    logic [WORD_W-1:0] arm;
    logic [WORD_W-1:0] rc;
    logic [WORD_W-1:0] go;
  } regs_t;

  // Word-aligned offsets 0x00..0x18 map to one register each; all else is unmapped.
  function automatic sel_e decode_addr(input logic [31:0] addr);
    sel_e s;
    s = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr[31:2])
        30'd0:   s = SEL_CFG;
        30'd1:   s = SEL_STAT;
        30'd2:   s = SEL_TRIG;
        30'd3:   s = SEL_FLAG;
        30'd4:   s = SEL_ARM;
        30'd5:   s = SEL_RC;
        30'd6:   s = SEL_GO;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] strb);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < int'(LANES); i++) begin
      m[i*8 +: 8] = {8{strb[i]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/csr_wr_chan.sv
module csr_wr_chan
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter bit          RO_WR_SLVERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  output logic [1:0]        bresp,
  input  logic              bready,
  output sel_e              wr_sel,
  output logic [WORD_W-1:0] wr_mask,
  output logic [WORD_W-1:0] wr_bits
);

  logic  pend_q;
  resp_e resp_q;
  resp_e resp_d;
  logic  fire;
  sel_e  sel;

  // Address and data are taken together, only while no response waits.
  assign fire    = awvalid && wvalid && !pend_q;
  assign awready = wvalid && !pend_q;
  assign wready  = awvalid && !pend_q;

  assign sel     = decode_addr(32'(awaddr));
  assign wr_sel  = fire ? sel : SEL_NONE;
  assign wr_mask = lane_mask(wstrb);
  assign wr_bits = wdata & wr_mask;

  always_comb begin
    if (sel == SEL_NONE) begin
      resp_d = RESP_DECERR;
    end else if ((sel == SEL_STAT) && RO_WR_SLVERR) begin
      resp_d = RESP_SLVERR;
    end else begin
      resp_d = RESP_OKAY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      resp_q <= RESP_OKAY;
    end else if (fire) begin
      pend_q <= 1'b1;
      resp_q <= resp_d;
    end else if (bready) begin
      pend_q <= 1'b0;
    end
  end

  assign bvalid = pend_q;
  assign bresp  = resp_q;

endmodule

// File: rtl/csr_rd_chan.sv
module csr_rd_chan
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  regs_t             regs,
  input  logic [WORD_W-1:0] status,
  output sel_e              rd_sel
);

  logic              pend_q;
  logic [WORD_W-1:0] data_q;
  resp_e             resp_q;
  logic [WORD_W-1:0] data_d;
  logic              fire;
  sel_e              sel;

  assign fire    = arvalid && !pend_q;
  assign arready = !pend_q;
  assign sel     = decode_addr(32'(araddr));
  assign rd_sel  = fire ? sel : SEL_NONE;

  // Read path: what each register shows, independent of its write rule.
  always_comb begin
    case (sel)
      SEL_CFG:  data_d = regs.cfg;
      SEL_STAT: data_d = status;
      SEL_FLAG: data_d = regs.flag;
      SEL_ARM:  data_d = regs.arm;
      SEL_RC:   data_d = regs.rc;
      SEL_GO:   data_d = regs.go;
      default:  data_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
      resp_q <= RESP_OKAY;
    end else if (fire) begin
      pend_q <= 1'b1;
      data_q <= data_d;
      resp_q <= (sel == SEL_NONE) ? RESP_DECERR : RESP_OKAY;
    end else if (rready) begin
      pend_q <= 1'b0;
    end
  end

  assign rvalid = pend_q;
  assign rdata  = data_q;
  assign rresp  = resp_q;

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_bank_pkg::*;
#(
  parameter logic [31:0] CFG_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              wr_sel,
  input  logic [WORD_W-1:0] wr_mask,
  input  logic [WORD_W-1:0] wr_bits,
  input  sel_e              rd_sel,
  input  logic [WORD_W-1:0] evt_set,
  input  logic [WORD_W-1:0] arm_clr,
  input  logic [WORD_W-1:0] rc_evt,
  input  logic [WORD_W-1:0] done,
  output regs_t             regs,
  output logic [WORD_W-1:0] trig
);

  regs_t             q;
  logic [WORD_W-1:0] trig_q;
  logic [WORD_W-1:0] ones_cfg, ones_trig, ones_flag, ones_arm, ones_go;

  // Write path: per register, the lane-enabled ones only when that register is hit.
  assign ones_cfg  = (wr_sel == SEL_CFG)  ? wr_bits : '0;
  assign ones_trig = (wr_sel == SEL_TRIG) ? wr_bits : '0;
  assign ones_flag = (wr_sel == SEL_FLAG) ? wr_bits : '0;
  assign ones_arm  = (wr_sel == SEL_ARM)  ? wr_bits : '0;
  assign ones_go   = (wr_sel == SEL_GO)   ? wr_bits : '0;

  // Plain storage: only enabled lanes take new data.
  always_ff @(posedge clk) begin
    if (!rst_n) q.cfg <= CFG_RESET;
    else if (wr_sel == SEL_CFG) q.cfg <= (q.cfg & ~wr_mask) | ones_cfg;
  end

  // Clear-by-one flags: the hardware set is applied last so it wins.
  always_ff @(posedge clk) begin
    if (!rst_n) q.flag <= '0;
    else        q.flag <= (q.flag & ~ones_flag) | evt_set;
  end

  // Set-by-one enables: the software set is applied last so it wins.
  always_ff @(posedge clk) begin
    if (!rst_n) q.arm <= '0;
    else        q.arm <= (q.arm & ~arm_clr) | ones_arm;
  end

  // Clear-on-read events: cleared on the address handshake, new events survive.
  always_ff @(posedge clk) begin
    if (!rst_n)                q.rc <= '0;
    else if (rd_sel == SEL_RC) q.rc <= rc_evt;
    else                       q.rc <= q.rc | rc_evt;
  end

  // Self-clearing start bits: done clears, a new start in the same cycle wins.
  always_ff @(posedge clk) begin
    if (!rst_n) q.go <= '0;
    else        q.go <= (q.go & ~done) | ones_go;
  end

  // Trigger pulses last one cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= ones_trig;
  end

  assign regs = q;
  assign trig = trig_q;

endmodule

// File: rtl/csr_typed_bank.sv
module csr_typed_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter bit          RO_WR_SLVERR = 1'b1,
  parameter logic [31:0] CFG_RESET    = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [31:0]       hw_status_i,
  input  logic [31:0]       evt_set_i,
  input  logic [31:0]       arm_clr_i,
  input  logic [31:0]       rc_evt_i,
  input  logic [31:0]       done_i,
  output logic [31:0]       cfg_o,
  output logic [31:0]       trig_o,
  output logic [31:0]       arm_o,
  output logic [31:0]       go_o
);

  sel_e              wr_sel;
  sel_e              rd_sel;
  logic [WORD_W-1:0] wr_mask;
  logic [WORD_W-1:0] wr_bits;
  regs_t             regs;

  csr_wr_chan #(.ADDR_W(ADDR_W), .RO_WR_SLVERR(RO_WR_SLVERR)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bresp(s_bresp), .bready(s_bready),
    .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_bits(wr_bits)
  );

  csr_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .regs(regs), .status(hw_status_i), .rd_sel(rd_sel)
  );

  csr_regfile #(.CFG_RESET(CFG_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_bits(wr_bits), .rd_sel(rd_sel),
    .evt_set(evt_set_i), .arm_clr(arm_clr_i), .rc_evt(rc_evt_i), .done(done_i),
    .regs(regs), .trig(trig_o)
  );

  assign cfg_o = regs.cfg;
  assign arm_o = regs.arm;
  assign go_o  = regs.go;

endmodule

// File: rtl/csr_typed_bank_chk.sv
module csr_typed_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic [1:0]  rresp,
  input logic [31:0] trig,
  input logic [31:0] evt_set,
  input logic [31:0] flag,
  input logic [31:0] rc_evt,
  input logic [31:0] rc
);

  assert_b_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

  assert_r_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));

  assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != 32'h0) |=> (trig == 32'h0));

  assert_flag_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 32'h0) |=> ((flag & $past(evt_set)) == $past(evt_set)));

  assert_rc_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_evt != 32'h0) |=> ((rc & $past(rc_evt)) == $past(rc_evt)));

  assert_bresp_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp != 2'b01));

  assert_rresp_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rresp != 2'b01) && (rresp != 2'b10));

endmodule

bind csr_typed_bank csr_typed_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
  .trig(trig_o), .evt_set(evt_set_i), .flag(regs.flag),
  .rc_evt(rc_evt_i), .rc(regs.rc)
);

// File: tb/csr_typed_bank_tb.sv
module csr_typed_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_bready = 1'b1, s_rready = 1'b1;
  logic        s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [31:0] hw_status_i = '0, evt_set_i = '0, arm_clr_i = '0, rc_evt_i = '0, done_i = '0;
  logic [31:0] cfg_o, trig_o, arm_o, go_o;

  always #10 clk = ~clk;

  csr_typed_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .hw_status_i(hw_status_i), .evt_set_i(evt_set_i), .arm_clr_i(arm_clr_i),
    .rc_evt_i(rc_evt_i), .done_i(done_i),
    .cfg_o(cfg_o), .trig_o(trig_o), .arm_o(arm_o), .go_o(go_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  logic [31:0] m_cfg, m_flag, m_arm, m_rc, m_go, m_trig, m_rdata, msk;
  logic        m_bvalid, m_rvalid, wf, rf, w1;
  logic [1:0]  m_bresp, m_rresp;
  int          wa, ra, m_raddr, m_waddr;
  int          wr_acc = 0, rd_acc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '0; m_flag = '0; m_arm = '0; m_rc = '0; m_go = '0; m_trig = '0;
      m_bvalid = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_bresp = 2'b00; m_rresp = 2'b00;
      m_raddr = 0; m_waddr = 0;
    end else begin
      wf = s_awvalid && s_wvalid && !m_bvalid;
      rf = s_arvalid && !m_rvalid;
      wa = int'(s_awaddr);
      ra = int'(s_araddr);
      for (int b = 0; b < 4; b++) msk[b*8 +: 8] = s_wstrb[b] ? 8'hFF : 8'h00;
      if (rf) begin
        m_rvalid = 1'b1; m_raddr = ra; m_rresp = 2'b00; rd_acc++;
        case (ra)
          0:  m_rdata = m_cfg;
          4:  m_rdata = hw_status_i;
          8:  m_rdata = '0;
          12: m_rdata = m_flag;
          16: m_rdata = m_arm;
          20: m_rdata = m_rc;
          24: m_rdata = m_go;
          default: begin m_rdata = '0; m_rresp = 2'b11; end
        endcase
      end else if (s_rready) begin
        m_rvalid = 1'b0;
      end
      if (wf) begin
        m_bvalid = 1'b1; m_waddr = wa; wr_acc++;
        if (wa == 4) m_bresp = 2'b10;
        else if (wa >= 0 && wa <= 24 && (wa % 4) == 0) m_bresp = 2'b00;
        else m_bresp = 2'b11;
      end else if (s_bready) begin
        m_bvalid = 1'b0;
      end
      for (int i = 0; i < 32; i++) begin
        w1 = wf && msk[i] && s_wdata[i];
        if (wf && wa == 0 && msk[i]) m_cfg[i] = s_wdata[i];
        m_trig[i] = w1 && (wa == 8);
        if (evt_set_i[i]) m_flag[i] = 1'b1;
        else if (w1 && wa == 12) m_flag[i] = 1'b0;
        if (w1 && wa == 16) m_arm[i] = 1'b1;
        else if (arm_clr_i[i]) m_arm[i] = 1'b0;
        if (rc_evt_i[i]) m_rc[i] = 1'b1;
        else if (rf && ra == 20) m_rc[i] = 1'b0;
        if (w1 && wa == 24) m_go[i] = 1'b1;
        else if (done_i[i]) m_go[i] = 1'b0;
      end
    end
  end

  function automatic string rd_tag(input int a);
    case (a)
      0: return "R1 rdata"; 4: return "R2 rdata"; 8: return "R3 rdata";
      12: return "R4 rdata"; 16: return "R5 rdata"; 20: return "R6 rdata";
      24: return "R7 rdata"; default: return "R9 rdata";
    endcase
  endfunction

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cfg_o == m_cfg, "R1 cfg_o", cfg_o, m_cfg);
      check(trig_o == m_trig, "R3 trig_o", trig_o, m_trig);
      check(arm_o == m_arm, "R5 arm_o", arm_o, m_arm);
      check(go_o == m_go, "R7 go_o", go_o, m_go);
      check(s_bvalid == m_bvalid, "R10 bvalid", 32'(s_bvalid), 32'(m_bvalid));
      check(s_rvalid == m_rvalid, "R10 rvalid", 32'(s_rvalid), 32'(m_rvalid));
      if (m_bvalid)
        check(s_bresp == m_bresp, (m_waddr == 4) ? "R2 bresp" : "R9 bresp",
              32'(s_bresp), 32'(m_bresp));
      if (m_rvalid) begin
        check(s_rdata == m_rdata, rd_tag(m_raddr), s_rdata, m_rdata);
        check(s_rresp == m_rresp, "R9 rresp", 32'(s_rresp), 32'(m_rresp));
      end
    end
  end

  // Hardware pulses applied in the same cycle as the next bus handshake.
  logic [31:0] co_evt = '0, co_clr = '0, co_rc = '0, co_done = '0;

  task automatic apply_co();
    evt_set_i = co_evt; arm_clr_i = co_clr; rc_evt_i = co_rc; done_i = co_done;
  endtask

  task automatic drop_co();
    evt_set_i = '0; arm_clr_i = '0; rc_evt_i = '0; done_i = '0;
    co_evt = '0; co_clr = '0; co_rc = '0; co_done = '0;
  endtask

  task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int hold);
    int base;
    base = wr_acc;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1'b1; s_wvalid = 1'b1;
    apply_co();
    if (hold > 0) s_bready = 1'b0;
    do @(negedge clk); while (wr_acc == base);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    drop_co();
    repeat (hold) @(negedge clk);
    s_bready = 1'b1;
    while (m_bvalid) @(negedge clk);
  endtask

  task automatic axi_read(input logic [7:0] a, input int hold);
    int base;
    base = rd_acc;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    apply_co();
    if (hold > 0) s_rready = 1'b0;
    do @(negedge clk); while (rd_acc == base);
    s_arvalid = 1'b0;
    drop_co();
    repeat (hold) @(negedge clk);
    s_rready = 1'b1;
    while (m_rvalid) @(negedge clk);
  endtask

  task automatic hw_pulse(input logic [31:0] e, input logic [31:0] c, input logic [31:0] r, input logic [31:0] dn);
    @(negedge clk);
    evt_set_i = e; arm_clr_i = c; rc_evt_i = r; done_i = dn;
    @(negedge clk);
    evt_set_i = '0; arm_clr_i = '0; rc_evt_i = '0; done_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=<%0d", 20000, 20000);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_o == 32'h0 && arm_o == 32'h0 && go_o == 32'h0, "R1 reset state", cfg_o | arm_o | go_o, 32'h0);

    // R1 storage, R8 partial lanes
    axi_write(8'h00, 32'hA5A5_1234, 4'hF, 0);
    axi_read(8'h00, 0);
    axi_write(8'h00, 32'hFFFF_FFFF, 4'b0101, 2);
    check(cfg_o == 32'hA5FF_12FF, "R8 cfg lanes", cfg_o, 32'hA5FF_12FF);
    axi_read(8'h00, 3);

    // R2 live status, write ignored with SLVERR
    hw_status_i = 32'h1357_9BDF;
    axi_read(8'h04, 0);
    axi_write(8'h04, 32'hFFFF_FFFF, 4'hF, 0);
    hw_status_i = 32'h2468_ACE0;
    axi_read(8'h04, 0);

    // R3 trigger pulses, read returns zero
    axi_write(8'h08, 32'hDEAD_BEEF, 4'b0001, 0);
    axi_write(8'h08, 32'h0000_0000, 4'hF, 0);
    axi_read(8'h08, 0);

    // R4 clear-by-one flags
    hw_pulse(32'h0000_0F0F, '0, '0, '0);
    axi_read(8'h0C, 0);
    axi_write(8'h0C, 32'h0000_0005, 4'hF, 0);
    axi_write(8'h0C, 32'h0000_0000, 4'hF, 0);
    co_evt = 32'h0000_0002;
    axi_write(8'h0C, 32'h0000_0002, 4'hF, 0);
    axi_read(8'h0C, 0);
    axi_write(8'h0C, 32'hFFFF_FFFF, 4'b0010, 0);
    axi_read(8'h0C, 0);

    // R5 set-by-one enables
    axi_write(8'h10, 32'h0000_0003, 4'hF, 0);
    axi_write(8'h10, 32'h0000_0004, 4'hF, 0);
    check(arm_o == 32'h0000_0007, "R5 arm set keeps", arm_o, 32'h7);
    hw_pulse('0, 32'h0000_0001, '0, '0);
    co_clr = 32'h0000_0002;
    axi_write(8'h10, 32'h0000_0002, 4'hF, 0);
    check(arm_o == 32'h0000_0006, "R5 sw set beats clear", arm_o, 32'h6);
    axi_read(8'h10, 0);

    // R6 clear-on-read
    hw_pulse('0, '0, 32'h0000_0011, '0);
    axi_read(8'h14, 0);
    axi_read(8'h14, 0);
    co_rc = 32'h0000_0008;
    axi_read(8'h14, 0);
    axi_read(8'h14, 0);
    hw_pulse('0, '0, 32'h0000_0100, '0);
    axi_write(8'h14, 32'hFFFF_FFFF, 4'hF, 0);
    axi_read(8'h14, 0);

    // R7 self-clearing start
    axi_write(8'h18, 32'h0000_0001, 4'hF, 0);
    axi_read(8'h18, 0);
    hw_pulse('0, '0, '0, 32'h0000_0001);
    check(go_o == 32'h0, "R7 done clears", go_o, 32'h0);
    co_done = 32'h0000_0001;
    axi_write(8'h18, 32'h0000_0003, 4'hF, 0);
    check(go_o == 32'h3, "R7 set beats done", go_o, 32'h3);
    axi_read(8'h18, 2);

    // R9 unmapped and unaligned
    axi_write(8'h40, 32'hFFFF_FFFF, 4'hF, 0);
    axi_write(8'h02, 32'hFFFF_FFFF, 4'hF, 0);
    axi_read(8'h1C, 0);
    axi_read(8'h01, 1);
    axi_read(8'h00, 0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule